// File: doc/BRIEF.md
# Inertial sensor bring-up and reconfiguration sequencer

This block brings a motion sensor from power-up to a usable state over a register-access bus. After reset it reads the sensor's identity register and records whether the value is the expected one. A wrong identity raises a warning flag but does not stop the sequence. It then commands a soft reset and waits for the sensor's digital startup. Next it writes one configuration word, which selects the gyroscope and accelerometer filter bandwidths and turns on the automatic self-test with a fixed repetition count. Finally it waits out the mechanical startup, every self-test pass and the filter flush, and then reports ready.

The sensor accepts its configuration word only once after each reset. For that reason, a bandwidth change requested through the select inputs always replays the whole soft reset, configure and settle sequence. The identity read is not repeated on a restart. Each channel accepts 50 Hz or 400 Hz, and any other value is refused with an error.

A separate bus engine carries out the register transactions. All delays are counted in milliseconds, from a tick derived from the clock frequency parameter. A second parameter shortens every delay for simulation.

Top module: `sensor_bringup_seq`

## Requirements
- R1: After reset is released, `busy` is high, `done` and `error` are low, and the first bus request is a read (`req_write`=0) of address 0x00.
- R2: When the identity read returns a value other than 0x0024, `id_mismatch` is set and stays set until reset, and the sequence still continues to `done`. A value of 0x0024 leaves `id_mismatch` low.
- R3: The soft reset is a write of 0x00B6 to address 0x2F. It follows the identity read at power-up, and it is the first request of every restart.
- R4: After the soft-reset write is accepted, no request is issued for exactly 120 × CYC_PER_MS cycles. The configuration write follows immediately after that.
- R5: The configuration is a write to address 0x0A. Bit 0 is 1, bit 1 is the gyroscope bandwidth, bit 2 is the accelerometer bandwidth, bit 3 is 1 (automatic self-test), bits 6:4 hold BIST_COUNT−1 and all other bits are 0. A bandwidth bit is 1 for 50 Hz and 0 for 400 Hz. A request holds its address and data until its response arrives.
- R6: After the configuration write is accepted, `done` rises after exactly (100 + BIST_COUNT × 140 + 60) × CYC_PER_MS cycles, and `busy` falls in the same cycle.
- R7: Out of reset both bandwidths are 400 Hz. With BIST_COUNT=3 the first configuration word is therefore 0x0029.
- R8: A `bw_req` pulse while not busy, with both `acc_hz` and `gyr_hz` equal to 50 or 400, clears `error`, loads the new bandwidths and restarts at the soft-reset write with no identity read.
- R9: A `bw_req` pulse while not busy with any other frequency on either channel sets `error`. It issues no bus request, leaves `done` as it was and loads no bandwidth.
- R10: A response with `rsp_err`=1 ends the sequence. `error` goes high, `busy` and `done` go low, and no request is issued until a valid bandwidth request restarts the sequence, which also clears `error`.
- R11: A `bw_req` pulse while `busy` is high has no effect. The sequence in progress writes the bandwidths it already held.
- R12: `busy` stays high from the start of a sequence until `done` or `error`, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| bw_req | input | 1 | One-cycle pulse requesting new filter bandwidths |
| acc_hz | input | FREQ_W | Requested accelerometer filter corner in Hz (50 or 400) |
| gyr_hz | input | FREQ_W | Requested gyroscope filter corner in Hz (50 or 400) |
| req_valid | output | 1 | Register request pending, held until `rsp_valid` |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | One-cycle completion of the pending request |
| rsp_err | input | 1 | The completed request failed on the bus |
| rsp_rdata | input | 16 | Read data returned with `rsp_valid` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sensor configured and settled |
| error | output | 1 | Bus failure or refused bandwidth request |
| id_mismatch | output | 1 | Identity register did not read 0x0024 |

## Verification
The bench builds the block with CLK_HZ=50_000 and TIME_SCALE=10, which gives 5 cycles per millisecond. The 120 ms startup wait then lasts 600 cycles, and the 580 ms settle time for three self-test passes lasts 2900 cycles. At these lengths a single run can afford several complete sequences: power-up, restarts with each bandwidth mix, a request ignored in mid-wait, a refused frequency, an injected bus failure with recovery, and a second power-up with a wrong identity. A behavioural model predicts every output in every cycle, and exact wait lengths are measured at the request port.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    ST_ID_RD,
    ST_RST_WR,
    ST_RST_WAIT,
    ST_CFG_WR,
    ST_CFG_WAIT,
    ST_READY,
    ST_FAULT
  } seq_state_e;

  localparam logic [7:0]  ADDR_ID        = 8'h00;
  localparam logic [7:0]  ADDR_CFG       = 8'h0A;
  localparam logic [7:0]  ADDR_CMD       = 8'h2F;
  localparam logic [15:0] CMD_SOFT_RESET = 16'h00B6;
  localparam logic [15:0] ID_EXPECTED    = 16'h0024;

  localparam int unsigned NARROW_HZ = 50;
  localparam int unsigned WIDE_HZ   = 400;

  localparam int unsigned STARTUP_MS = 120;
  localparam int unsigned MECH_MS    = 100;
  localparam int unsigned SELFTEST_MS = 140;
  localparam int unsigned FLUSH_MS   = 60;

endpackage

// File: rtl/sbs_ms_timer.sv
module sbs_ms_timer #(
  parameter int unsigned CYC_PER_MS = 1000,
  parameter int unsigned MS_W       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [MS_W-1:0] target_ms,
  output logic            expire
);

  localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             wrap;

  assign wrap   = (pre_q == PRE_LAST);
  assign expire = run && wrap && (ms_q == target_ms - MS_W'(1));

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (!run) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (wrap) begin
      pre_d = '0;
      ms_d  = ms_q + MS_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  // R4
  ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ms_q < target_ms));

endmodule

// File: rtl/sbs_bw_decode.sv
module sbs_bw_decode
  import sbs_pkg::*;
#(
  parameter int unsigned FREQ_W = 16
) (
  input  logic [FREQ_W-1:0] freq_hz,
  output logic              ok,
  output logic              narrow
);

  always_comb begin
    ok     = 1'b0;
    narrow = 1'b0;
    if (freq_hz == FREQ_W'(NARROW_HZ)) begin
      ok     = 1'b1;
      narrow = 1'b1;
    end else if (freq_hz == FREQ_W'(WIDE_HZ)) begin
      ok = 1'b1;
    end
  end

endmodule

// File: rtl/sensor_bringup_seq.sv
module sensor_bringup_seq
  import sbs_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TIME_SCALE = 1,
  parameter int unsigned BIST_COUNT = 3,
  parameter int unsigned FREQ_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_req,
  input  logic [FREQ_W-1:0] acc_hz,
  input  logic [FREQ_W-1:0] gyr_hz,
  output logic              req_valid,
  output logic              req_write,
  output logic [7:0]        req_addr,
  output logic [15:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              id_mismatch
);

  localparam int unsigned CYC_RAW    = CLK_HZ / (1000 * TIME_SCALE);
  localparam int unsigned CYC_PER_MS = (CYC_RAW < 1) ? 1 : CYC_RAW;
  localparam int unsigned CFG_MS     = MECH_MS + BIST_COUNT * SELFTEST_MS + FLUSH_MS;
  localparam int unsigned MS_W       = $clog2(CFG_MS + 1);
  localparam int unsigned NUM_CH     = 2;
  localparam logic [2:0]  REP_FIELD  = 3'(BIST_COUNT - 1);

  seq_state_e state_q, state_d;
  logic [NUM_CH-1:0] bw_q;        // [0] gyro, [1] accel; 1 = 50 Hz
  logic              bw_load;
  logic              err_q, err_set, err_clr;
  logic              mism_q, mism_set;
  logic [NUM_CH-1:0][FREQ_W-1:0] ch_hz;
  logic [NUM_CH-1:0] ch_ok, ch_narrow;
  logic [15:0]       cfg_word;
  logic              tmr_run, tmr_expire;
  logic [MS_W-1:0]   tmr_target;

  assign ch_hz[0] = gyr_hz;
  assign ch_hz[1] = acc_hz;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bw
    sbs_bw_decode #(.FREQ_W(FREQ_W)) u_dec (
      .freq_hz (ch_hz[g]),
      .ok      (ch_ok[g]),
      .narrow  (ch_narrow[g])
    );
  end

  assign cfg_word = {9'd0, REP_FIELD, 1'b1, bw_q, 1'b1};

  assign tmr_run    = (state_q == ST_RST_WAIT) || (state_q == ST_CFG_WAIT);
  assign tmr_target = (state_q == ST_RST_WAIT) ? MS_W'(STARTUP_MS) : MS_W'(CFG_MS);

  sbs_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .target_ms (tmr_target),
    .expire    (tmr_expire)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    mism_set = 1'b0;
    bw_load  = 1'b0;
    unique case (state_q)
      ST_ID_RD: if (rsp_valid) begin
        if (rsp_err) begin
          state_d = ST_FAULT;
          err_set = 1'b1;
        end else begin
          mism_set = (rsp_rdata != ID_EXPECTED);
          state_d  = ST_RST_WR;
        end
      end
      ST_RST_WR: if (rsp_valid) begin
        state_d = rsp_err ? ST_FAULT : ST_RST_WAIT;
        err_set = rsp_err;
      end
      ST_RST_WAIT: if (tmr_expire) state_d = ST_CFG_WR;
      ST_CFG_WR: if (rsp_valid) begin
        state_d = rsp_err ? ST_FAULT : ST_CFG_WAIT;
        err_set = rsp_err;
      end
      ST_CFG_WAIT: if (tmr_expire) state_d = ST_READY;
      ST_READY, ST_FAULT: if (bw_req) begin
        if (&ch_ok) begin
          bw_load = 1'b1;
          err_clr = 1'b1;
          state_d = ST_RST_WR;
        end else begin
          err_set = 1'b1;
        end
      end
      default: state_d = ST_FAULT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ID_RD;
      bw_q    <= '0;
      err_q   <= 1'b0;
      mism_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (bw_load)  bw_q   <= ch_narrow;
      if (err_set)  err_q  <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (mism_set) mism_q <= 1'b1;
    end
  end

  // request port
  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = ADDR_ID;
    req_wdata = '0;
    unique case (state_q)
      ST_ID_RD: req_valid = 1'b1;
      ST_RST_WR: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = ADDR_CMD;
        req_wdata = CMD_SOFT_RESET;
      end
      ST_CFG_WR: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = ADDR_CFG;
        req_wdata = cfg_word;
      end
      default: ;
    endcase
  end

  assign busy        = (state_q != ST_READY) && (state_q != ST_FAULT);
  assign done        = (state_q == ST_READY);
  assign error       = err_q;
  assign id_mismatch = mism_q;

  // R12
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10
  bus_err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid && rsp_err) |=> (error && !busy && !done));

  // R11
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bw_req) |=> $stable(bw_q));

  // R9
  bad_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bw_req && !(&ch_ok)) |=> (error && !req_valid));

  // R6
  done_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q == ST_CFG_WAIT));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)));

endmodule

// File: tb/sim_sensor_bringup_seq.sv
module sim_sensor_bringup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 50_000;
  localparam int TIME_SCALE = 10;
  localparam int BIST       = 3;
  localparam int CYC        = CLK_HZ / (1000 * TIME_SCALE);
  localparam int RST_CYC    = 120 * CYC;
  localparam int CFG_CYC    = (100 + BIST * 140 + 60) * CYC;
  localparam int LAT        = 2;

  logic        clk, rst_n, bw_req;
  logic [15:0] acc_hz, gyr_hz;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        busy, done, error, id_mismatch;

  sensor_bringup_seq #(
    .CLK_HZ(CLK_HZ), .TIME_SCALE(TIME_SCALE), .BIST_COUNT(BIST), .FREQ_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bw_req(bw_req), .acc_hz(acc_hz), .gyr_hz(gyr_hz),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .error(error),
    .id_mismatch(id_mismatch)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int m_ph;   // 0 id read, 1 reset write, 2 reset wait, 3 cfg write, 4 settle, 5 ready, 6 fault
  int m_cnt;
  bit m_err, m_mism, m_acc50, m_gyr50;

  // responder and measurement state
  logic [15:0] id_val;
  int  err_txn;
  int  txn_no = 0;
  int  rsp_cnt = 0;
  int  reads_cnt = 0;
  logic [15:0] last_cfg;
  logic [7:0]  last_rst_addr;
  logic [15:0] last_rst_data;
  int  quiet = 0;
  int  rst_gap = -1;
  int  cfg_gap = -1;
  bit  prev_rv = 0;
  bit  prev_done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit freq_ok(input int f);
    return (f == 50) || (f == 400);
  endfunction

  function automatic logic [15:0] cfg_exp(input bit a50, input bit g50);
    return 16'h0009 | (16'(g50) << 1) | (16'(a50) << 2) | (16'(BIST - 1) << 4);
  endfunction

  function automatic string tag_of(input int ph);
    case (ph)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      6: return "R10";
      default: return "R12";
    endcase
  endfunction

  // reference model, advanced on the same edge the design uses
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_err = 0; m_mism = 0; m_acc50 = 0; m_gyr50 = 0;
    end else begin
      case (m_ph)
        0, 1, 3: if (rsp_valid) begin
          if (rsp_err) begin
            m_ph = 6; m_err = 1;
          end else if (m_ph == 0) begin
            m_mism = (rsp_rdata != 16'h0024);
            m_ph = 1;
          end else if (m_ph == 1) begin
            m_ph = 2; m_cnt = RST_CYC;
          end else begin
            m_ph = 4; m_cnt = CFG_CYC;
          end
        end
        2, 4: begin
          m_cnt--;
          if (m_cnt == 0) m_ph = m_ph + 1;
        end
        default: if (bw_req) begin
          if (freq_ok(int'(acc_hz)) && freq_ok(int'(gyr_hz))) begin
            m_acc50 = (acc_hz == 16'd50);
            m_gyr50 = (gyr_hz == 16'd50);
            m_err = 0;
            m_ph = 1;
          end else begin
            m_err = 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison, bus responder, gap measurement
  always @(negedge clk) begin
    if (rst_n) begin
      automatic string t = tag_of(m_ph);
      automatic bit exp_rv = (m_ph == 0) || (m_ph == 1) || (m_ph == 3);
      chk(busy == (m_ph < 5), "R12", "busy", busy, m_ph < 5);
      chk(done == (m_ph == 5), t, "done", done, m_ph == 5);
      chk(error == m_err, t, "error", error, m_err);
      chk(id_mismatch == m_mism, "R2", "id_mismatch", id_mismatch, m_mism);
      chk(req_valid == exp_rv, t, "req_valid", req_valid, exp_rv);
      if (req_valid && exp_rv) begin
        case (m_ph)
          0: begin
            chk(req_write == 1'b0, "R1", "req_write", req_write, 0);
            chk(req_addr == 8'h00, "R1", "req_addr", req_addr, 8'h00);
          end
          1: begin
            chk(req_write == 1'b1, "R3", "req_write", req_write, 1);
            chk(req_addr == 8'h2F, "R3", "req_addr", req_addr, 8'h2F);
            chk(req_wdata == 16'h00B6, "R3", "req_wdata", req_wdata, 16'h00B6);
          end
          default: begin
            chk(req_write == 1'b1, "R5", "req_write", req_write, 1);
            chk(req_addr == 8'h0A, "R5", "req_addr", req_addr, 8'h0A);
            chk(req_wdata == cfg_exp(m_acc50, m_gyr50), "R5", "req_wdata",
                req_wdata, cfg_exp(m_acc50, m_gyr50));
          end
        endcase
      end
    end

    if (!rst_n) begin
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0; rsp_cnt = 0;
    end else if (rsp_valid) begin
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0; rsp_cnt = 0;
    end else if (req_valid) begin
      if (rsp_cnt == LAT) begin
        rsp_valid = 1'b1;
        rsp_err   = (txn_no == err_txn);
        rsp_rdata = (!req_write && req_addr == 8'h00) ? id_val : 16'h0000;
        if (!req_write) reads_cnt++;
        if (req_write && !rsp_err && req_addr == 8'h0A) last_cfg = req_wdata;
        if (req_write && !rsp_err && req_wdata == 16'h00B6) begin
          last_rst_addr = req_addr;
          last_rst_data = req_wdata;
        end
        txn_no++;
      end else begin
        rsp_cnt++;
      end
    end

    if (req_valid && !prev_rv) begin
      if (req_addr == 8'h0A) rst_gap = quiet;
      quiet = 0;
    end else if (!req_valid && busy) begin
      quiet++;
    end
    if (done && !prev_done) cfg_gap = quiet;
    prev_rv   = req_valid;
    prev_done = done;
  end

  task automatic pulse_bw(input int a, input int g);
    @(posedge clk); #2;
    acc_hz = 16'(a);
    gyr_hz = 16'(g);
    bw_req = 1'b1;
    @(posedge clk); #2;
    bw_req = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
    @(posedge clk); #2;
  endtask

  initial begin
    rst_n = 1'b0; bw_req = 1'b0; acc_hz = 16'd400; gyr_hz = 16'd400;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    id_val = 16'h0024; err_txn = -1;
    last_cfg = '0; last_rst_addr = '0; last_rst_data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk(busy == 1'b1, "R1", "busy after reset", busy, 1);
    chk(done == 1'b0 && error == 1'b0, "R1", "done/error after reset", {done, error}, 0);
    chk(req_valid && !req_write && req_addr == 8'h00, "R1", "first request",
        {req_valid, req_write, req_addr}, {1'b1, 1'b0, 8'h00});

    // power-up sequence with defaults
    wait_end();
    chk(done == 1'b1, "R6", "done after power-up", done, 1);
    chk(rst_gap == RST_CYC, "R4", "startup wait cycles", rst_gap, RST_CYC);
    chk(cfg_gap == CFG_CYC, "R6", "settle wait cycles", cfg_gap, CFG_CYC);
    chk(last_cfg == 16'h0029, "R7", "default config word", last_cfg, 16'h0029);
    chk(id_mismatch == 1'b0, "R2", "matching identity", id_mismatch, 0);
    chk(last_rst_addr == 8'h2F && last_rst_data == 16'h00B6, "R3", "soft reset write",
        {last_rst_addr, last_rst_data}, {8'h2F, 16'h00B6});

    // R8 restart with accel narrow, no identity read
    begin
      automatic int reads0 = reads_cnt;
      pulse_bw(50, 400);
      chk(busy == 1'b1 && done == 1'b0, "R8", "restart busy", {busy, done}, 2'b10);
      wait_end();
      chk(last_cfg == 16'h002D, "R8", "config accel 50", last_cfg, 16'h002D);
      chk(reads_cnt == reads0, "R8", "no identity read on restart", reads_cnt, reads0);
      chk(rst_gap == RST_CYC, "R4", "startup wait on restart", rst_gap, RST_CYC);
    end

    // R11 request during startup wait ignored
    pulse_bw(50, 50);
    repeat (40) @(posedge clk);
    #2;
    chk(busy == 1'b1 && req_valid == 1'b0, "R11", "inside startup wait", {busy, req_valid}, 2'b10);
    pulse_bw(400, 400);
    wait_end();
    chk(last_cfg == 16'h002F, "R11", "config keeps held bandwidths", last_cfg, 16'h002F);
    chk(done == 1'b1, "R11", "done after ignored request", done, 1);

    // R9 refused frequency
    pulse_bw(100, 50);
    chk(error == 1'b1, "R9", "error on bad frequency", error, 1);
    chk(done == 1'b1 && req_valid == 1'b0, "R9", "no restart", {done, req_valid}, 2'b10);
    repeat (20) @(posedge clk);
    #2;
    chk(req_valid == 1'b0 && busy == 1'b0, "R9", "bus stays idle", {req_valid, busy}, 0);

    // R10 bus failure on configuration write, then recovery
    err_txn = txn_no + 1;
    pulse_bw(400, 50);
    chk(error == 1'b0, "R8", "valid request clears error", error, 0);
    wait_end();
    chk(error == 1'b1 && done == 1'b0 && busy == 1'b0, "R10", "abort state",
        {error, done, busy}, 3'b100);
    repeat (30) @(posedge clk);
    #2;
    chk(req_valid == 1'b0 && done == 1'b0, "R10", "stays idle after abort", {req_valid, done}, 0);
    err_txn = -1;
    pulse_bw(400, 400);
    chk(error == 1'b0 && busy == 1'b1, "R10", "restart clears error", {error, busy}, 2'b01);
    wait_end();
    chk(done == 1'b1 && last_cfg == 16'h0029, "R10", "recovered config",
        last_cfg, 16'h0029);

    // R2 wrong identity at a fresh power-up
    id_val = 16'h0031;
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    wait_end();
    chk(id_mismatch == 1'b1, "R2", "identity mismatch flag", id_mismatch, 1);
    chk(done == 1'b1 && error == 1'b0, "R2", "sequence continues", {done, error}, 2'b10);

    repeat (5) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule